// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is the control engine of a single DMA channel. Software places a chain of descriptors in memory, each 32-byte aligned and made of four 32-bit words: source address (offset 0), destination address (offset 4), next-link word (offset 8) and byte count (offset 12). Software then points the current-descriptor register at the first descriptor and raises the start bit. The sequencer reads each descriptor and issues data moves of at most `BEAT_BYTES` bytes until the count is used up. It then either follows the next link or, if the end-of-list flag is set, stops and reports completion.

A small register port holds four registers: mode (index 0), status (index 1), current descriptor (index 2) and remaining byte count (index 3). A single memory request port carries both descriptor reads and move commands. Faults, aborts and completions are reported in write-one-to-clear status bits, and a maskable interrupt line reflects them.

Top module: `lds_channel`

## Requirements
- R1: After reset the mode and status registers read 0, `irq` is low, and `mem_req` stays low while the channel is not busy.
- R2: A write to mode that takes bit 0 (start) from 0 to 1 while the channel is not busy sets busy (status bit 4), clears halted (status bit 5) and fetches the four descriptor words with non-move requests at the current-descriptor address plus 0, 4, 8 and 12.
- R3: Each descriptor's bytes are moved in requests of length min(remaining, `BEAT_BYTES`) with ascending source and destination addresses. Register 3 shows the bytes remaining and reads 0 after normal completion. The count field is the low `CNT_W` bits of word 3.
- R4: Bit 0 of the next-link word is the end-of-list flag and bits 4:1 are ignored. Without the flag, the current-descriptor register takes the next link with its low 5 bits cleared and fetching continues. With the flag, the channel stops after that descriptor, sets end-of-links (status bit 0), clears busy and leaves the current-descriptor register on the last descriptor.
- R5: Completing the moves of any descriptor sets end-of-segment (status bit 1).
- R6: The start bit is not cleared by the hardware. Rewriting a 1 over a 1 does not restart the channel, and the channel never becomes busy without a start edge.
- R7: A descriptor with a zero count sets programming-error (status bit 2), issues no move and stops the channel without setting halted.
- R8: A memory response with `mem_err` during a fetch or a move sets transfer-error (status bit 3), clears busy, sets halted and leaves the current-descriptor register on the failing descriptor.
- R9: Writing mode with bit 1 (abort) set while busy stops the channel in the next cycle: no further request, busy clear, halted set.
- R10: Writing 1 to a status bit among bits 3:0 clears it, and writing 0 leaves it.
- R11: `irq` is high exactly when (mode bit 2 is set and status bit 2 or 3 is set) or (mode bit 3 is set and status bit 0 is set).
- R12: Writes to the current-descriptor register are ignored while busy. Otherwise the register stores the value with its low 5 bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request valid, held until acknowledged |
| mem_move | output | 1 | 1: data move, 0: descriptor word read |
| mem_addr | output | DW | Read address or move source |
| mem_dst | output | DW | Move destination |
| mem_len | output | LEN_W | Move length in bytes |
| mem_rdata | input | DW | Descriptor word read data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_err | input | 1 | Completion carries an error |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the points where a sequencer of this kind usually breaks. One is a chain whose next links carry junk in the reserved flag bits: a design that fails to mask them fetches from a misaligned address and moves the wrong bytes. Another is a count that is not a multiple of the beat size: a wrong final chunk either leaves residue in the byte-count register or moves too many bytes. A zero-count descriptor and an injected memory error on the first move of a middle descriptor check that the fault bits, the halted state and the current-descriptor value point at the right descriptor. Aborting a stalled fetch, rewriting start over start, and writing the current-descriptor register while busy expose a design that restarts, keeps requesting, or corrupts its pointer.

// File: rtl/lds_pkg.sv
package lds_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MOVE} lds_state_e;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CDAR = 2'd2;
  localparam logic [1:0] REG_BCNT = 2'd3;

  localparam int MB_START = 0;
  localparam int MB_ABORT = 1;
  localparam int MB_ERRIE = 2;
  localparam int MB_EOLIE = 3;

  localparam int SB_EOL  = 0;
  localparam int SB_SEG  = 1;
  localparam int SB_PERR = 2;
  localparam int SB_TERR = 3;

  localparam int DESC_ALIGN_BITS = 5;
endpackage

// File: rtl/lds_ctrl_regs.sv
module lds_ctrl_regs
  import lds_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          busy,
  input  logic          ev_eol,
  input  logic          ev_seg,
  input  logic          ev_perr,
  input  logic          ev_terr,
  output logic [3:0]    mode_q,
  output logic [3:0]    flags_q,
  output logic          go,
  output logic          abort_req,
  output logic          irq
);
  logic       mode_wr, stat_wr;
  logic [3:0] mode_d, flags_d, flag_set, flag_clr;

  assign mode_wr   = reg_wr && (reg_addr == REG_MODE);
  assign stat_wr   = reg_wr && (reg_addr == REG_STAT);
  assign go        = mode_wr && reg_wdata[MB_START] && !mode_q[MB_START] && !busy;
  assign abort_req = mode_wr && reg_wdata[MB_ABORT] && busy;

  always_comb begin
    flag_set = '0;
    flag_set[SB_EOL]  = ev_eol;
    flag_set[SB_SEG]  = ev_seg;
    flag_set[SB_PERR] = ev_perr;
    flag_set[SB_TERR] = ev_terr;
    flag_clr = stat_wr ? reg_wdata[3:0] : 4'd0;
    flags_d  = (flags_q & ~flag_clr) | flag_set;
    mode_d   = mode_wr ? reg_wdata[3:0] : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      flags_q <= '0;
    end else begin
      if (mode_wr) mode_q <= mode_d;
      flags_q <= flags_d;
    end
  end

  assign irq = (mode_q[MB_ERRIE] && (flags_q[SB_PERR] || flags_q[SB_TERR])) ||
               (mode_q[MB_EOLIE] && flags_q[SB_EOL]);
endmodule

// File: rtl/lds_walker.sv
module lds_walker
  import lds_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CNT_W      = 26,
  parameter int BEAT_BYTES = 8,
  localparam int LEN_W     = $clog2(BEAT_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             abort_req,
  input  logic             cdar_wr,
  input  logic [DW-1:0]    cdar_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  output logic             mem_req,
  output logic             mem_move,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dst,
  output logic [LEN_W-1:0] mem_len,
  output logic             busy,
  output logic             halted,
  output logic [DW-1:0]    cdar,
  output logic [CNT_W-1:0] bcnt,
  output logic             ev_eol,
  output logic             ev_seg,
  output logic             ev_perr,
  output logic             ev_terr
);
  lds_state_e state_q, state_d;
  logic [1:0]       widx_q, widx_d;
  logic             busy_d, halted_d, xfer, dp_en;
  logic [DW-1:0]    src_q, src_d, dst_q, dst_d, nxt_q, nxt_d, cdar_d;
  logic [CNT_W-1:0] bcnt_d, fetched_cnt;
  logic [LEN_W-1:0] chunk;

  assign xfer        = mem_req && mem_ack;
  assign fetched_cnt = mem_rdata[CNT_W-1:0];
  assign chunk       = (bcnt > CNT_W'(BEAT_BYTES)) ? LEN_W'(BEAT_BYTES) : LEN_W'(bcnt);
  assign dp_en       = xfer || cdar_wr;

  always_comb begin
    state_d = state_q;  widx_d = widx_q;  busy_d = busy;  halted_d = halted;
    src_d = src_q;  dst_d = dst_q;  nxt_d = nxt_q;  bcnt_d = bcnt;  cdar_d = cdar;
    ev_eol = 1'b0;  ev_seg = 1'b0;  ev_perr = 1'b0;  ev_terr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = ST_FETCH;  widx_d = 2'd0;  busy_d = 1'b1;  halted_d = 1'b0;
        end else if (cdar_wr) begin
          cdar_d = {cdar_wdata[DW-1:DESC_ALIGN_BITS], {DESC_ALIGN_BITS{1'b0}}};
        end
      end
      ST_FETCH: begin
        if (xfer && mem_err) begin
          ev_terr = 1'b1;  state_d = ST_IDLE;  busy_d = 1'b0;  halted_d = 1'b1;
        end else if (xfer) begin
          widx_d = widx_q + 2'd1;
          unique case (widx_q)
            2'd0: src_d = mem_rdata;
            2'd1: dst_d = mem_rdata;
            2'd2: nxt_d = mem_rdata;
            default: begin
              bcnt_d = fetched_cnt;
              if (fetched_cnt == '0) begin
                ev_perr = 1'b1;  state_d = ST_IDLE;  busy_d = 1'b0;
              end else begin
                state_d = ST_MOVE;
              end
            end
          endcase
        end
      end
      default: begin
        if (xfer && mem_err) begin
          ev_terr = 1'b1;  state_d = ST_IDLE;  busy_d = 1'b0;  halted_d = 1'b1;
        end else if (xfer) begin
          bcnt_d = bcnt - CNT_W'(chunk);
          src_d  = src_q + DW'(chunk);
          dst_d  = dst_q + DW'(chunk);
          if (bcnt == CNT_W'(chunk)) begin
            ev_seg = 1'b1;
            if (nxt_q[0]) begin
              ev_eol = 1'b1;  state_d = ST_IDLE;  busy_d = 1'b0;
            end else begin
              cdar_d  = {nxt_q[DW-1:DESC_ALIGN_BITS], {DESC_ALIGN_BITS{1'b0}}};
              state_d = ST_FETCH;  widx_d = 2'd0;
            end
          end
        end
      end
    endcase
    if (abort_req) begin
      state_d = ST_IDLE;  busy_d = 1'b0;  halted_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  widx_q <= '0;  busy <= 1'b0;  halted <= 1'b0;
      src_q <= '0;  dst_q <= '0;  nxt_q <= '0;  bcnt <= '0;  cdar <= '0;
    end else begin
      state_q <= state_d;  widx_q <= widx_d;  busy <= busy_d;  halted <= halted_d;
      if (dp_en) begin
        src_q <= src_d;  dst_q <= dst_d;  nxt_q <= nxt_d;  bcnt <= bcnt_d;  cdar <= cdar_d;
      end
    end
  end

  assign mem_req  = (state_q != ST_IDLE);
  assign mem_move = (state_q == ST_MOVE);
  assign mem_addr = (state_q == ST_FETCH) ? (cdar + DW'({widx_q, 2'b00})) : src_q;
  assign mem_dst  = dst_q;
  assign mem_len  = chunk;
endmodule

// File: rtl/lds_channel.sv
module lds_channel
  import lds_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CNT_W      = 26,
  parameter int BEAT_BYTES = 8,
  localparam int LEN_W     = $clog2(BEAT_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             mem_req,
  output logic             mem_move,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dst,
  output logic [LEN_W-1:0] mem_len,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  output logic             irq
);
  logic             rst_meta, rst_sync_n;
  logic             busy, halted, go, abort_req;
  logic             ev_eol, ev_seg, ev_perr, ev_terr;
  logic [3:0]       mode_q, flags_q;
  logic [DW-1:0]    cdar;
  logic [CNT_W-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  lds_ctrl_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .ev_eol(ev_eol), .ev_seg(ev_seg),
    .ev_perr(ev_perr), .ev_terr(ev_terr), .mode_q(mode_q), .flags_q(flags_q),
    .go(go), .abort_req(abort_req), .irq(irq)
  );

  lds_walker #(.DW(DW), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)) u_walker (
    .clk(clk), .rst_n(rst_sync_n), .go(go), .abort_req(abort_req),
    .cdar_wr(reg_wr && (reg_addr == REG_CDAR)), .cdar_wdata(reg_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_req(mem_req), .mem_move(mem_move), .mem_addr(mem_addr),
    .mem_dst(mem_dst), .mem_len(mem_len), .busy(busy), .halted(halted),
    .cdar(cdar), .bcnt(bcnt), .ev_eol(ev_eol), .ev_seg(ev_seg),
    .ev_perr(ev_perr), .ev_terr(ev_terr)
  );

  always_comb begin
    unique case (reg_addr)
      REG_MODE: reg_rdata = {{(DW-4){1'b0}}, mode_q};
      REG_STAT: reg_rdata = {{(DW-6){1'b0}}, halted, busy, flags_q};
      REG_CDAR: reg_rdata = cdar;
      default:  reg_rdata = {{(DW-CNT_W){1'b0}}, bcnt};
    endcase
  end
endmodule

// File: rtl/lds_checker.sv
module lds_checker #(
  parameter int DW         = 32,
  parameter int BEAT_BYTES = 8,
  parameter int LEN_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic             mem_req,
  input logic             mem_move,
  input logic             mem_ack,
  input logic             mem_err,
  input logic [LEN_W-1:0] mem_len,
  input logic             irq,
  input logic             busy,
  input logic             halted,
  input logic             go,
  input logic [3:0]       mode_q,
  input logic [DW-1:0]    cdar
);
  // R1
  idle_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  // R2
  start_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_req && !mem_move));
  // R3
  move_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_move) |-> (mem_len != '0 && int'(mem_len) <= BEAT_BYTES));
  // R6
  no_self_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> !busy);
  // R8
  fault_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> (!busy && halted));
  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd0 && reg_wdata[1]) |=> (!mem_req && halted));
  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[2] && !mode_q[3]) |-> !irq);
  // R12
  cdar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd2 && !(mem_req && mem_ack)) |=> $stable(cdar));
endmodule

bind lds_channel lds_checker #(.DW(DW), .BEAT_BYTES(BEAT_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_move(mem_move),
  .mem_ack(mem_ack), .mem_err(mem_err), .mem_len(mem_len), .irq(irq),
  .busy(busy), .halted(halted), .go(go), .mode_q(mode_q), .cdar(cdar)
);

// File: tb/lds_channel_bench.sv
module lds_channel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int BEAT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic mem_req, mem_move;
  logic [DW-1:0] mem_addr, mem_dst;
  logic [3:0] mem_len;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_ack = 1'b0;
  logic mem_err = 1'b0;
  logic irq;

  lds_channel #(.DW(DW), .CNT_W(26), .BEAT_BYTES(BEAT)) u_lds_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_move(mem_move), .mem_addr(mem_addr), .mem_dst(mem_dst),
    .mem_len(mem_len), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [31:0] dmem [64];
  logic [31:0] exp_src [64], exp_dst [64];
  int exp_len [64];
  int exp_n = 0, mv_cnt = 0, mv_bad = 0, req_cnt = 0, err_idx = -1;
  bit stall_all = 0, seen_first = 0;
  logic [31:0] first_addr;
  logic first_move;
  int slot_of [8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // memory responder: random stalls, optional injected error
  always @(negedge clk) begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    if (rst_n && mem_req && !seen_first) begin
      seen_first = 1; first_addr = mem_addr; first_move = mem_move;
    end
    if (rst_n && mem_req && !stall_all && ($urandom % 4 != 0)) begin
      mem_ack = 1'b1;
      if (req_cnt == err_idx) mem_err = 1'b1;
      else if (!mem_move) mem_rdata = dmem[mem_addr[7:2]];
      else begin
        if (mv_cnt >= exp_n || mem_addr != exp_src[mv_cnt] ||
            mem_dst != exp_dst[mv_cnt] || int'(mem_len) != exp_len[mv_cnt]) mv_bad++;
        mv_cnt++;
      end
      req_cnt++;
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata; reg_addr = 2'd0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      reg_read(2'd1, s);
      if (!s[4]) return;
    end
    chk(0, "R2 channel never went idle", s, 32'h0);
  endtask

  // builds a chain in memory and the expected move list (the model)
  task automatic build_chain(input int n, input int off, input bit zero_first);
    exp_n = 0; mv_cnt = 0; mv_bad = 0; req_cnt = 0; seen_first = 0;
    for (int i = 0; i < n; i++) slot_of[i] = ((i * 3) + off) % 8;
    for (int i = 0; i < n; i++) begin
      int base = slot_of[i] * 8;
      int cnt = zero_first ? 0 : 1 + ($urandom % 40);
      logic [31:0] s = $urandom, d = $urandom;
      logic [31:0] nx = (i == n - 1) ? 32'h1 : 32'(slot_of[i + 1] * 32);
      nx[4:1] = 4'($urandom);
      dmem[base] = s; dmem[base+1] = d; dmem[base+2] = nx;
      dmem[base+3] = {6'($urandom), 26'(cnt)};
      while (cnt > 0) begin
        int c = (cnt > BEAT) ? BEAT : cnt;
        exp_src[exp_n] = s; exp_dst[exp_n] = d; exp_len[exp_n] = c;
        exp_n++; s += 32'(c); d += 32'(c); cnt -= c;
      end
    end
  endtask

  task automatic launch(input int ie);
    reg_write(2'd2, 32'(slot_of[0] * 32));
    reg_write(2'd0, 32'(ie));
    reg_write(2'd0, 32'(ie | 1));
  endtask

  logic [31:0] v;

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    reg_read(2'd1, v); chk(v == 0, "R1 status after reset", v, 0);
    reg_read(2'd0, v); chk(v == 0, "R1 mode after reset", v, 0);
    chk(!irq && !mem_req, "R1 irq/req after reset", {irq, mem_req}, 0);

    // random chains
    for (int t = 0; t < 5; t++) begin
      int n = 1 + t % 4;
      bit eolie = t[0];
      build_chain(n, t, 0);
      launch(eolie ? 8 : 0);
      wait_idle();
      chk(first_addr == 32'(slot_of[0] * 32) && !first_move, "R2 first fetch address", first_addr, 32'(slot_of[0] * 32));
      chk(mv_bad == 0 && mv_cnt == exp_n, "R3 move sequence", mv_cnt, exp_n);
      reg_read(2'd3, v); chk(v == 0, "R3 byte count after completion", v, 0);
      reg_read(2'd1, v); chk(v[5:0] == 6'b000011, "R4 R5 status at end of chain", v, 32'h3);
      reg_read(2'd2, v); chk(v == 32'(slot_of[n - 1] * 32), "R4 cdar on last descriptor", v, 32'(slot_of[n - 1] * 32));
      chk(irq == eolie, "R11 end-of-links irq enable", irq, eolie);
      reg_read(2'd0, v); chk(v[0] == 1'b1, "R6 start bit kept", v, 1);
      reg_write(2'd0, v);
      repeat (5) @(negedge clk);
      chk(!mem_req, "R6 no restart on 1 over 1", mem_req, 0);
      reg_write(2'd1, 32'h0);
      reg_read(2'd1, v); chk(v[1:0] == 2'b11, "R10 zero write keeps bits", v, 3);
      reg_write(2'd1, 32'hF);
      reg_read(2'd1, v); chk(v[3:0] == 0, "R10 one write clears bits", v, 0);
      chk(!irq, "R11 irq drops after clear", irq, 0);
      reg_write(2'd0, 32'h0);
    end

    // zero count
    build_chain(1, 2, 1);
    launch(4);
    wait_idle();
    reg_read(2'd1, v); chk(v[5:0] == 6'b000100, "R7 programming error only", v, 4);
    chk(mv_cnt == 0, "R7 no moves", mv_cnt, 0);
    chk(irq, "R11 error irq", irq, 1);
    reg_write(2'd1, 32'hF); reg_write(2'd0, 0);

    // transfer error on first move of second descriptor
    build_chain(3, 5, 0);
    err_idx = 4 + (exp_len[0] == 0 ? 0 : 0);
    begin
      int c0 = 0;
      for (int k = 0; k < exp_n; k++) if (exp_src[k] - exp_src[0] < 32'd64 && k < 5) c0 = c0;
      c0 = (dmem[slot_of[0]*8+3][25:0] + 7) / 8;
      err_idx = 4 + c0 + 4;
    end
    launch(4);
    wait_idle();
    err_idx = -1;
    reg_read(2'd1, v); chk(v[5] && v[3] && !v[4], "R8 transfer error halts", v, 32'h28);
    reg_read(2'd2, v); chk(v == 32'(slot_of[1] * 32), "R8 cdar at failing descriptor", v, 32'(slot_of[1] * 32));
    chk(irq, "R11 transfer error irq", irq, 1);
    reg_write(2'd1, 32'hF); reg_write(2'd0, 0);

    // abort while stalled, plus cdar write while busy
    build_chain(2, 1, 0);
    stall_all = 1;
    launch(0);
    repeat (4) @(negedge clk);
    reg_write(2'd2, 32'h000000E0);
    reg_read(2'd2, v); chk(v == 32'(slot_of[0] * 32), "R12 cdar write ignored while busy", v, 32'(slot_of[0] * 32));
    reg_write(2'd0, 32'h3);
    reg_read(2'd1, v); chk(v[5] && !v[4], "R9 abort halts", v, 32'h20);
    chk(!mem_req, "R9 no request after abort", mem_req, 0);
    stall_all = 0;
    reg_write(2'd0, 0);
    reg_write(2'd2, 32'h1234567F);
    reg_read(2'd2, v); chk(v == 32'h12345660, "R12 cdar low bits cleared", v, 32'h12345660);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule